// File: doc/BRIEF.md
# Four-Channel Register-Programmed Pulse-Width Modulator

This block generates four independent pulse-width-modulated pins from one input clock. Software programs each channel through a simple single-cycle 32-bit register port. A write strobe, a read strobe, a byte address and a data bus are all that is needed. Each channel holds a cycle length and an active-time length, both counted in input clock ticks. Three global masks, with one bit per channel, select inverted polarity, run the channel, and let it drive its pin.

Cycle and active-time values are latched into a channel's working counter only when its run bit goes from 0 to 1. Software therefore rewrites the values, then clears and sets the run bit to apply them. Until that restart the running waveform keeps its old shape. A channel that is stopped, gated off or given a zero cycle length holds its pin at the inactive level for its polarity.

Top module: `multi_pwm_ctrl`

## Requirements
- R1: After reset every register reads 0 and every pin `pwm_o` is low.
- R2: Each register reads back its last written value. Channel n's active-time register sits at byte offset n*8 and its cycle-length register at n*8+4, both 32 bits. The polarity mask is at 0x40, the run mask at 0x44 and the enable mask at 0xD0. In each mask, bit n belongs to channel n, and bits 31:4 read 0.
- R3: A read of any other offset returns 0, and a write to any other offset changes no register and no pin.
- R4: When a channel's run bit rises at write edge E, its pin is inactive in the cycle after E. Counting j=0 from the cycle after edge E+1, the pin is active exactly when (j mod cycle) < active time.
- R5: Values written to the cycle or active-time registers while a channel runs do not change its waveform until the run bit is cleared and set again.
- R6: A cycle length of 0 keeps the pin at its inactive level while the channel runs.
- R7: An active time of at least the cycle length keeps the pin active for the whole cycle. An active time of 0 keeps it inactive.
- R8: Clearing a run bit forces that pin to its inactive level from the cycle after the write.
- R9: A channel whose enable bit is 0 holds its pin at its inactive level, from the cycle after the write.
- R10: A polarity bit of 0 makes the active level high. A polarity bit of 1 makes the active level low and the inactive level high. A change takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when no read |
| pwm_o | output | 4 | PWM pins, bit n for channel n |

## Verification
A wrong working counter or a stale latched value shows on the pin within one programmed cycle. It appears as a shifted edge, a wrong count of active ticks or a missed wrap. A reload on any run write other than a rising one shows up as an immediate change in active-tick density after a mid-run rewrite. A faulty edge detector shows in the first cycle after the run write, where the pin must still be inactive. Polarity and gating faults show on the pin in the very next cycle after the mask write.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int unsigned AW        = 8;
  localparam int unsigned DW        = 32;
  localparam int unsigned CH_STRIDE = 8;
  localparam logic [AW-1:0] OFS_ACT  = 8'h00;
  localparam logic [AW-1:0] OFS_CYC  = 8'h04;
  localparam logic [AW-1:0] OFS_POL  = 8'h40;
  localparam logic [AW-1:0] OFS_RUN  = 8'h44;
  localparam logic [AW-1:0] OFS_OEN  = 8'hD0;
endpackage

// File: rtl/pwmq_regfile.sv
module pwmq_regfile
  import pwmq_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NCH-1:0][DW-1:0] act_o,
  output logic [NCH-1:0][DW-1:0] cyc_o,
  output logic [NCH-1:0]      pol_o,
  output logic [NCH-1:0]      run_o,
  output logic [NCH-1:0]      oen_o
);
  localparam int unsigned PAD = DW - NCH;

  logic [NCH-1:0] hit_act, hit_cyc;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      hit_act[c] = (addr_i == AW'(c * CH_STRIDE) + OFS_ACT);
      hit_cyc[c] = (addr_i == AW'(c * CH_STRIDE) + OFS_CYC);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_o[c] <= '0;
        cyc_o[c] <= '0;
      end else if (wr_en_i) begin
        if (hit_act[c]) act_o[c] <= wdata_i;
        if (hit_cyc[c]) cyc_o[c] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o <= '0;
      run_o <= '0;
      oen_o <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_POL) pol_o <= wdata_i[NCH-1:0];
      if (addr_i == OFS_RUN) run_o <= wdata_i[NCH-1:0];
      if (addr_i == OFS_OEN) oen_o <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == OFS_POL) rdata_o = {{PAD{1'b0}}, pol_o};
      if (addr_i == OFS_RUN) rdata_o = {{PAD{1'b0}}, run_o};
      if (addr_i == OFS_OEN) rdata_o = {{PAD{1'b0}}, oen_o};
      for (int c = 0; c < NCH; c++) begin
        if (hit_act[c]) rdata_o = act_o[c];
        if (hit_cyc[c]) rdata_o = cyc_o[c];
      end
    end
  end
endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] cyc_i,
  input  logic [DW-1:0] act_i,
  output logic          active_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          run_d;
  logic [DW-1:0] cyc_w, act_w, cnt_q;
  logic          run_rise;

  assign run_rise = run_i & ~run_d;

  // working copies reload only on a rising run bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_d <= 1'b0;
      cyc_w <= '0;
      act_w <= '0;
      cnt_q <= '0;
    end else begin
      run_d <= run_i;
      if (run_rise) begin
        cyc_w <= cyc_i;
        act_w <= act_i;
        cnt_q <= '0;
      end else if (!run_i || cyc_w == '0) begin
        cnt_q <= '0;
      end else if (cnt_q >= cyc_w - ONE) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign active_o = run_i & run_d & (cyc_w != '0) & (cnt_q < act_w);
endmodule

// File: rtl/multi_pwm_ctrl.sv
module multi_pwm_ctrl
  import pwmq_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [7:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [NCH-1:0] pwm_o
);
  logic [NCH-1:0][DW-1:0] act_q, cyc_q;
  logic [NCH-1:0]         pol_q, run_q, oen_q, active;

  pwmq_regfile #(.NCH(NCH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .act_o   (act_q),
    .cyc_o   (cyc_q),
    .pol_o   (pol_q),
    .run_o   (run_q),
    .oen_o   (oen_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwmq_channel #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[c]),
      .cyc_i    (cyc_q[c]),
      .act_i    (act_q[c]),
      .active_o (active[c])
    );
  end

  assign pwm_o = pol_q ^ (oen_q & active);
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
  import pwmq_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic           rd_en_i,
  input logic [7:0]     addr_i,
  input logic [31:0]    wdata_i,
  input logic [31:0]    rdata_o,
  input logic [NCH-1:0] pwm_o,
  input logic [NCH-1:0] pol_q,
  input logic [NCH-1:0] run_q,
  input logic [NCH-1:0] oen_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (pwm_o == '0 && rdata_o == '0);
    end
  end

  a_r3_unaligned_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[1:0] != 2'b00) |-> rdata_o == '0);

  a_r10_pol_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_POL) |=> pol_q == $past(wdata_i[NCH-1:0]));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r8_stopped_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[c] |-> pwm_o[c] == pol_q[c]);
    a_r4_first_cycle_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_q[c]) |-> pwm_o[c] == pol_q[c]);
    a_r9_gated_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oen_q[c] |-> pwm_o[c] == pol_q[c]);
  end
endmodule

bind multi_pwm_ctrl pwmq_checker #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .pol_q   (pol_q),
  .run_q   (run_q),
  .oen_q   (oen_q)
);

// File: tb/multi_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module multi_pwm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_POL = 8'h40, A_RUN = 8'h44, A_OEN = 8'hD0;

  // {ch[47:40], cycle[39:24], active[23:8], pol[7:0]}
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {8'd0, 16'd5, 16'd2, 8'd0},
    {8'd1, 16'd3, 16'd1, 8'd1},
    {8'd2, 16'd4, 16'd4, 8'd0},
    {8'd3, 16'd3, 16'd7, 8'd1},
    {8'd0, 16'd6, 16'd0, 8'd0},
    {8'd1, 16'd1, 16'd1, 8'd0},
    {8'd2, 16'd7, 16'd3, 8'd1}
  };

  multi_pwm_ctrl u_multi_pwm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic lvl(int j, int cyc, int act, logic pol);
    if (cyc == 0) return pol;
    return pol ^ ((j % cyc) < act);
  endfunction

  task automatic start_ch(int ch);
    wr(A_RUN, 32'h0);
    wr(A_RUN, 32'(1 << ch));
  endtask

  task automatic wave(string req, int ch, int cyc, int act, logic pol, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(req, {28'b0, pwm}, 32'(lvl(j, cyc, act, pol)) << ch);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pins", {28'b0, pwm}, 32'h0);
    rd(A_POL, d); chk("R1 pol", d, 0);
    rd(A_RUN, d); chk("R1 run", d, 0);
    rd(A_OEN, d); chk("R1 oen", d, 0);
    rd(8'h1C, d); chk("R1 cyc3", d, 0);

    // R2 readback
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); chk("R2 act2", d, 32'h1234_5678);
    wr(8'h1C, 32'hCAFE_0001); rd(8'h1C, d); chk("R2 cyc3", d, 32'hCAFE_0001);
    wr(A_POL, 32'hFFFF_FFFF); rd(A_POL, d); chk("R2 pol mask", d, 32'hF);
    wr(A_OEN, 32'hFFFF_FFF5); rd(A_OEN, d); chk("R2 oen mask", d, 32'h5);
    wr(A_POL, 0); wr(A_OEN, 0);

    // R3 unmapped offsets
    wr(8'h48, 32'hDEAD_BEEF); rd(8'h48, d); chk("R3 rd 0x48", d, 0);
    wr(8'h41, 32'hFFFF_FFFF); rd(8'h41, d); chk("R3 rd 0x41", d, 0);
    rd(A_POL, d); chk("R3 pol untouched", d, 0);
    chk("R3 pins untouched", {28'b0, pwm}, 0);

    // R4 R7 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      int ch = int'(VEC[i][47:40]);
      int cy = int'(VEC[i][39:24]);
      int ac = int'(VEC[i][23:8]);
      logic pl = VEC[i][0];
      wr(A_RUN, 0);
      wr(8'(ch * 8), 32'(ac));
      wr(8'(ch * 8 + 4), 32'(cy));
      wr(A_POL, 32'(pl) << ch);
      wr(A_OEN, 32'(1 << ch));
      start_ch(ch);
      wave("R4 R7 R10 wave", ch, cy, ac, pl, 2 * cy + 2);
    end
    wr(A_RUN, 0); wr(A_POL, 0);

    // R5 no reload while running
    wr(8'h00, 1); wr(8'h04, 4); wr(A_OEN, 1);
    start_ch(0);
    wr(8'h00, 3); wr(8'h04, 6);
    wr(A_RUN, 1);
    cnt = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      cnt += int'(pwm[0]);
    end
    chk("R5 old shape kept", 32'(cnt), 2);
    start_ch(0);
    wave("R5 reload on restart", 0, 6, 3, 1'b0, 12);

    // R6 zero cycle length, inverted polarity
    wr(A_RUN, 0);
    wr(8'h18, 3); wr(8'h1C, 0); wr(A_POL, 32'h8); wr(A_OEN, 32'h8);
    start_ch(3);
    wave("R6 zero cycle", 3, 0, 3, 1'b1, 6);
    wr(A_RUN, 0); wr(A_POL, 0);

    // R8 stop
    wr(8'h08, 5); wr(8'h0C, 5); wr(A_OEN, 32'h2);
    start_ch(1);
    wave("R8 running", 1, 5, 5, 1'b0, 2);
    wr(A_RUN, 0);
    chk("R8 stop next cycle", {28'b0, pwm}, 0);
    wave("R8 stays stopped", 1, 0, 0, 1'b0, 3);

    // R9 R10 gating and polarity
    start_ch(1);
    wave("R9 enabled", 1, 5, 5, 1'b0, 1);
    wr(A_OEN, 0);
    chk("R9 gated low", {28'b0, pwm}, 0);
    wr(A_POL, 32'h2);
    chk("R10 gated inverted high", {28'b0, pwm}, 32'h2);
    wr(A_OEN, 32'h2);
    chk("R10 active inverted low", {28'b0, pwm}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule